// File: doc/BRIEF.md
# Host Byte Stream Pixel Assembler

This block sits behind the data port that a host uses to feed source pixels into a blit engine. The host writes one byte at a time; the block gathers those bytes into whole pixels of one, two or three bytes and passes each finished pixel to the next stage together with its horizontal and vertical position. Bytes are placed little-endian: the first byte of a pixel forms its least significant byte.

Alongside assembly the block tracks the raster walk. The horizontal position moves one step per pixel, up or down according to a direction bit. A running count of the bytes delivered in the current line is compared with the programmed destination line width in bytes. The pixel that brings the count to or past that width is flagged as the last of its line. After that pixel the horizontal position returns to its start value, the line count clears and the vertical position moves one step in its own direction. A start pulse loads the start coordinates and drops any partly gathered pixel. Raster operations and monochrome expansion are handled elsewhere.

Top module: `blit_pixel_assembler`

## Requirements
- R1: After reset, pix_valid and line_done are 0 and pix_x and pix_y are 0.
- R2: A cycle with start high loads pix_x from x_start and pix_y from y_start, and clears the partial-pixel and line byte counts, from the next cycle on.
- R3: With cfg_bpp equal to 1, 2 or 3, pix_valid rises for exactly one cycle, in the same cycle as the write that carries the last byte of a pixel; other writes leave it low. A cfg_bpp of 0 behaves exactly like 1.
- R4: In pix_data the first byte of a pixel sits in bits [7:0], the second in [15:8] and the third in [23:16]; bytes beyond the pixel size read as 0.
- R5: Cycles without a write produce no pixel and change neither the partial pixel nor pix_x or pix_y.
- R6: pix_x gives the position of the pixel being emitted; after a pixel that does not end its line, pix_x moves by +1 when x_dir_neg is 0 and by -1 when it is 1, wrapping modulo its width.
- R7: Each pixel adds its byte count to the line byte count; line_done is high together with the pixel whose new line count is greater than or equal to cfg_line_bytes, so a width of 0 ends every line on each pixel.
- R8: After a pixel with line_done, pix_x returns to x_start, the line count is 0 and pix_y moves by +1 when y_dir_neg is 0 and by -1 when it is 1.
- R9: A start in the same cycle as a write takes priority: that byte is dropped, no pixel is emitted, and the next pixel is built only from bytes written afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new blit: load start coordinates, clear counts |
| cfg_bpp | input | 2 | Bytes per pixel (0 and 1 mean one byte) |
| cfg_line_bytes | input | LINE_W | Destination line width in bytes |
| x_start | input | X_W | Horizontal start position |
| y_start | input | Y_W | Vertical start position |
| x_dir_neg | input | 1 | 1 makes x step downward |
| y_dir_neg | input | 1 | 1 makes y step downward |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | BYTE_W | Host byte |
| pix_valid | output | 1 | One-cycle pixel strobe |
| pix_data | output | 3*BYTE_W | Assembled pixel, little-endian |
| pix_x | output | X_W | Horizontal position of the pixel |
| pix_y | output | Y_W | Vertical position of the pixel |
| line_done | output | 1 | Pixel ends the current line |

## Verification
On every cycle the assertions check that a pixel strobe only appears with a write and never with start, that line_done never stands without a pixel, that the partial-byte counter stays in range and returns to zero after each pixel, that idle cycles hold both coordinates, and that each coordinate moves exactly one step in its direction or reloads its start value. What the values must be — the byte order inside a pixel, the zeroed upper bytes, which pixel of a line closes it for widths that are and are not multiples of the pixel size, and the dropped partial pixel after a start — can only be shown by the bench's scenarios with known byte streams.

// File: rtl/blitpa_pkg.sv
package blitpa_pkg;

   // Largest pixel the assembler builds, in bytes.
   localparam int unsigned MAX_BPP = 3;
   // Width of a bytes-per-pixel value.
   localparam int unsigned BPP_W   = $clog2(MAX_BPP + 1);

   // A programmed size of zero is taken as a single byte.
   function automatic logic [BPP_W-1:0] bpp_effective(input logic [BPP_W-1:0] cfg);
      return (cfg == '0) ? BPP_W'(1) : cfg;
   endfunction

endpackage

// File: rtl/blitpa_byte_gather.sv
module blitpa_byte_gather #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LANES  = 3,
   localparam int unsigned NW    = $clog2(LANES + 1),
   localparam int unsigned PIX_W = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [NW-1:0]     bpp,
   output logic              pix_done,
   output logic [PIX_W-1:0]  pix_data
);

   logic [NW-1:0] cnt_q;
   logic [NW-1:0] cnt_nx;
   logic          last_byte;
   logic          take;

   assign take      = wr_en && !clr;
   assign cnt_nx    = cnt_q + NW'(1);
   assign last_byte = (cnt_nx == bpp);
   assign pix_done  = take && last_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (wr_en)
         cnt_q <= last_byte ? '0 : cnt_nx;
   end

   // One lane per byte position; the top lane never needs storage because
   // its byte always arrives with the completing write.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [BYTE_W-1:0] lane_val;
      if (i < LANES - 1) begin : g_held
         logic [BYTE_W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hold_q <= '0;
            else if (take && (cnt_q == NW'(i)))
               hold_q <= wr_data;
         end
         assign lane_val = (cnt_q == NW'(i)) ? wr_data : hold_q;
      end else begin : g_direct
         assign lane_val = wr_data;
      end
      assign pix_data[i*BYTE_W +: BYTE_W] = (NW'(i) < bpp) ? lane_val : '0;
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < NW'(LANES));

   // R3
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_done |=> (cnt_q == '0));

   // R5
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/blitpa_coord_step.sv
module blitpa_coord_step #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         dir_neg,
   output logic [W-1:0] pos
);

   logic [W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (load)
         pos_q <= load_val;
      else if (step)
         pos_q <= dir_neg ? (pos_q - W'(1)) : (pos_q + W'(1));
   end

   assign pos = pos_q;

   // R6
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> ((pos_q - $past(pos_q) == W'(1)) || ($past(pos_q) - pos_q == W'(1))));

   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pos_q == $past(load_val)));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(pos_q));

endmodule

// File: rtl/blitpa_line_track.sv
module blitpa_line_track #(
   parameter int unsigned X_W    = 12,
   parameter int unsigned Y_W    = 12,
   parameter int unsigned LINE_W = 14,
   parameter int unsigned NW     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              pix_done,
   input  logic [NW-1:0]     bpp,
   input  logic [LINE_W-1:0] width,
   input  logic [X_W-1:0]    x_start,
   input  logic [Y_W-1:0]    y_start,
   input  logic              x_dir_neg,
   input  logic              y_dir_neg,
   output logic              line_end,
   output logic [X_W-1:0]    x_pos,
   output logic [Y_W-1:0]    y_pos
);

   logic [LINE_W-1:0] line_cnt_q;
   logic [LINE_W:0]   line_sum;

   // One spare bit keeps the sum from wrapping before the compare.
   assign line_sum = {1'b0, line_cnt_q} + (LINE_W+1)'(bpp);
   assign line_end = pix_done && (line_sum >= {1'b0, width});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_cnt_q <= '0;
      else if (clr || line_end)
         line_cnt_q <= '0;
      else if (pix_done)
         line_cnt_q <= line_sum[LINE_W-1:0];
   end

   blitpa_coord_step #(.W(X_W)) u_xstep (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (clr || line_end),
      .load_val (x_start),
      .step     (pix_done),
      .dir_neg  (x_dir_neg),
      .pos      (x_pos)
   );

   blitpa_coord_step #(.W(Y_W)) u_ystep (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (clr),
      .load_val (y_start),
      .step     (line_end),
      .dir_neg  (y_dir_neg),
      .pos      (y_pos)
   );

   // R8
   line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end || clr) |=> (line_cnt_q == '0));

   // R7
   line_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_done && !line_end && !clr) |=> (line_cnt_q > $past(line_cnt_q)));

endmodule

// File: rtl/blit_pixel_assembler.sv
module blit_pixel_assembler
   import blitpa_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned X_W    = 12,
   parameter int unsigned Y_W    = 12,
   parameter int unsigned LINE_W = 14,
   localparam int unsigned PIX_W = MAX_BPP * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        cfg_bpp,
   input  logic [LINE_W-1:0] cfg_line_bytes,
   input  logic [X_W-1:0]    x_start,
   input  logic [Y_W-1:0]    y_start,
   input  logic              x_dir_neg,
   input  logic              y_dir_neg,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              pix_valid,
   output logic [PIX_W-1:0]  pix_data,
   output logic [X_W-1:0]    pix_x,
   output logic [Y_W-1:0]    pix_y,
   output logic              line_done
);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be at least 1");
   end
   if (X_W < 1 || Y_W < 1) begin : g_bad_coord
      $error("coordinate widths must be at least 1");
   end
   if (LINE_W < BPP_W) begin : g_bad_line
      $error("LINE_W must hold a bytes-per-pixel value");
   end
   if (BPP_W != 2) begin : g_bad_bpp
      $error("cfg_bpp port assumes a two-bit size field");
   end

   logic [BPP_W-1:0] bpp_eff;
   logic             pix_done;
   logic             line_end;

   assign bpp_eff = bpp_effective(cfg_bpp);

   blitpa_byte_gather #(
      .BYTE_W (BYTE_W),
      .LANES  (MAX_BPP)
   ) u_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .bpp      (bpp_eff),
      .pix_done (pix_done),
      .pix_data (pix_data)
   );

   blitpa_line_track #(
      .X_W    (X_W),
      .Y_W    (Y_W),
      .LINE_W (LINE_W),
      .NW     (BPP_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start),
      .pix_done  (pix_done),
      .bpp       (bpp_eff),
      .width     (cfg_line_bytes),
      .x_start   (x_start),
      .y_start   (y_start),
      .x_dir_neg (x_dir_neg),
      .y_dir_neg (y_dir_neg),
      .line_end  (line_end),
      .x_pos     (pix_x),
      .y_pos     (pix_y)
   );

   assign pix_valid = pix_done;
   assign line_done = line_end;

   // R9
   pix_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (wr_en && !start));

   // R7
   line_needs_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> pix_valid);

   // R5
   idle_coord_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !start) |=> ($stable(pix_x) && $stable(pix_y)));

   // R3
   pix_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && bpp_eff != BPP_W'(1)) |=> !pix_valid);

   // R4
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && bpp_eff == BPP_W'(1)) |-> (pix_data[PIX_W-1:BYTE_W] == '0));

endmodule

// File: tb/blit_pixel_assembler_bench.sv
module blit_pixel_assembler_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  cfg_bpp = 2'd1;
   logic [13:0] cfg_line_bytes = '0;
   logic [11:0] x_start = '0;
   logic [11:0] y_start = '0;
   logic        x_dir_neg = 1'b0;
   logic        y_dir_neg = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        pix_valid;
   logic [23:0] pix_data;
   logic [11:0] pix_x;
   logic [11:0] pix_y;
   logic        line_done;

   int n_checks = 0;
   int n_fail   = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   blit_pixel_assembler u_blit_pixel_assembler (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (start),
      .cfg_bpp        (cfg_bpp),
      .cfg_line_bytes (cfg_line_bytes),
      .x_start        (x_start),
      .y_start        (y_start),
      .x_dir_neg      (x_dir_neg),
      .y_dir_neg      (y_dir_neg),
      .wr_en          (wr_en),
      .wr_data        (wr_data),
      .pix_valid      (pix_valid),
      .pix_data       (pix_data),
      .pix_x          (pix_x),
      .pix_y          (pix_y),
      .line_done      (line_done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle each: drive at the falling edge, outputs settle 1 ns later.
   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      start = 1'b0; wr_en = 1'b1; wr_data = d;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      #1;
   endtask

   task automatic begin_blit(input logic [1:0] bpp, input logic [13:0] width,
                             input logic [11:0] xs, input logic [11:0] ys,
                             input logic xn, input logic yn);
      @(negedge clk);
      cfg_bpp = bpp; cfg_line_bytes = width; x_start = xs; y_start = ys;
      x_dir_neg = xn; y_dir_neg = yn;
      start = 1'b1; wr_en = 1'b0;
      #1;
   endtask

   // Expect a finished pixel in the current cycle.
   task automatic expect_pix(input string tag, input logic [23:0] d, input logic [11:0] x,
                             input logic [11:0] y, input logic ld);
      chk(pix_valid == 1'b1, {tag, " valid"}, 32'(pix_valid), 32'd1);
      chk(pix_data == d, {tag, " data"}, 32'(pix_data), 32'(d));
      chk(pix_x == x, {tag, " x"}, 32'(pix_x), 32'(x));
      chk(pix_y == y, {tag, " y"}, 32'(pix_y), 32'(y));
      chk(line_done == ld, {tag, " line_done"}, 32'(line_done), 32'(ld));
   endtask

   task automatic expect_none(input string tag);
      chk(pix_valid == 1'b0, {tag, " no pixel"}, 32'(pix_valid), 32'd0);
      chk(line_done == 1'b0, {tag, " no line_done"}, 32'(line_done), 32'd0);
   endtask

   task automatic t_reset();
      #1;
      chk(pix_valid == 1'b0, "R1 pix_valid", 32'(pix_valid), 32'd0);
      chk(line_done == 1'b0, "R1 line_done", 32'(line_done), 32'd0);
      chk(pix_x == '0, "R1 pix_x", 32'(pix_x), 32'd0);
      chk(pix_y == '0, "R1 pix_y", 32'(pix_y), 32'd0);
   endtask

   // One-byte pixels, upward walk, width 4 bytes.
   task automatic t_bpp1();
      begin_blit(2'd1, 14'd4, 12'd10, 12'd5, 1'b0, 1'b0);
      wr(8'h01); expect_pix("R2 R3 R6 bpp1 p0", 24'h000001, 12'd10, 12'd5, 1'b0);
      wr(8'h02); expect_pix("R6 bpp1 p1", 24'h000002, 12'd11, 12'd5, 1'b0);
      wr(8'h03); expect_pix("R6 bpp1 p2", 24'h000003, 12'd12, 12'd5, 1'b0);
      wr(8'h84); expect_pix("R7 bpp1 p3 ends line", 24'h000084, 12'd13, 12'd5, 1'b1);
      wr(8'h05); expect_pix("R8 bpp1 next line", 24'h000005, 12'd10, 12'd6, 1'b0);
   endtask

   // Two-byte pixels, downward walk in both axes, width 6 bytes.
   task automatic t_bpp2();
      begin_blit(2'd2, 14'd6, 12'd100, 12'd20, 1'b1, 1'b1);
      wr(8'h11); expect_none("R3 bpp2 first byte");
      wr(8'h22); expect_pix("R4 bpp2 p0", 24'h002211, 12'd100, 12'd20, 1'b0);
      wr(8'h33); expect_none("R3 bpp2 partial");
      wr(8'h44); expect_pix("R6 bpp2 p1 down", 24'h004433, 12'd99, 12'd20, 1'b0);
      wr(8'h55);
      wr(8'h66); expect_pix("R7 bpp2 p2 ends line", 24'h006655, 12'd98, 12'd20, 1'b1);
      wr(8'h77);
      wr(8'h88); expect_pix("R8 bpp2 y down", 24'h008877, 12'd100, 12'd19, 1'b0);
   endtask

   // Three-byte pixels with idle gaps, width 5 (not a multiple of 3).
   task automatic t_bpp3();
      begin_blit(2'd3, 14'd5, 12'd7, 12'd0, 1'b0, 1'b0);
      wr(8'hAA);
      idle(); expect_none("R5 idle gap 1");
      wr(8'hBB);
      idle(); idle(); expect_none("R5 idle gap 2");
      wr(8'hCC); expect_pix("R4 R5 bpp3 p0", 24'hCCBBAA, 12'd7, 12'd0, 1'b0);
      idle(); expect_none("R5 idle after pixel");
      wr(8'hDD);
      wr(8'hEE);
      wr(8'hFF); expect_pix("R7 bpp3 6>=5 ends line", 24'hFFEEDD, 12'd8, 12'd0, 1'b1);
      wr(8'h01);
      wr(8'h02);
      wr(8'h03); expect_pix("R8 bpp3 next line", 24'h030201, 12'd7, 12'd1, 1'b0);
   endtask

   // Size 0 acts as one byte.
   task automatic t_bpp0();
      begin_blit(2'd0, 14'd2, 12'd3, 12'd40, 1'b0, 1'b0);
      wr(8'h5A); expect_pix("R3 bpp0 as one byte", 24'h00005A, 12'd3, 12'd40, 1'b0);
      wr(8'hA5); expect_pix("R3 bpp0 second pixel", 24'h0000A5, 12'd4, 12'd40, 1'b1);
   endtask

   // Start in the middle of a pixel, itself carrying a write.
   task automatic t_restart();
      begin_blit(2'd2, 14'd8, 12'd50, 12'd9, 1'b0, 1'b0);
      wr(8'h99);
      @(negedge clk);
      start = 1'b1; wr_en = 1'b1; wr_data = 8'hEE;
      #1;
      expect_none("R9 start with write");
      wr(8'h12); expect_none("R9 first byte after restart");
      wr(8'h34); expect_pix("R9 R2 pixel after restart", 24'h003412, 12'd50, 12'd9, 1'b0);
   endtask

   // Width 0: every pixel closes its line.
   task automatic t_width0();
      begin_blit(2'd1, 14'd0, 12'd2, 12'd9, 1'b1, 1'b0);
      wr(8'h01); expect_pix("R7 width0 p0", 24'h000001, 12'd2, 12'd9, 1'b1);
      wr(8'h02); expect_pix("R8 width0 p1", 24'h000002, 12'd2, 12'd10, 1'b1);
   endtask

   // X wraps below zero.
   task automatic t_wrap();
      begin_blit(2'd1, 14'd3, 12'd0, 12'd1, 1'b1, 1'b1);
      wr(8'h10); expect_pix("R6 wrap p0", 24'h000010, 12'd0, 12'd1, 1'b0);
      wr(8'h20); expect_pix("R6 wrap below zero", 24'h000020, 12'hFFF, 12'd1, 1'b0);
      wr(8'h30); expect_pix("R7 wrap ends line", 24'h000030, 12'hFFE, 12'd1, 1'b1);
      idle();
      chk(pix_y == 12'd0, "R8 y steps down", 32'(pix_y), 32'd0);
      chk(pix_x == 12'd0, "R8 x reloads", 32'(pix_x), 32'd0);
   endtask

   initial begin
      t_reset();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bpp1();
      t_bpp2();
      t_bpp3();
      t_bpp0();
      t_restart();
      t_width0();
      t_wrap();
      idle();
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done_flag) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule